// File: doc/BRIEF.md
# DRAM Row Boundary Address Decoder

This block turns a physical memory address into the DRAM row that holds it. Eight byte-wide boundary registers hold the cumulative end of rows 0 through n, counted in 8 MB units. Row n spans the range from the end of row n-1 (zero for row 0) up to, but not including, its own end. A row whose end equals the previous end is empty and never claims an address.

Each row also has a 2-bit page-size code and a banks flag (two or four banks). The decoder reports the code and flag of the selected row next to a one-hot row-hit vector and a row index. An address at or beyond the last boundary raises a miss. All of these outputs are combinational from the address. The boundaries, page codes and banks flags are loaded through a byte write port and change on the clock edge that samples the write.

When the memory is EDO, the page size is always reported as 2 KB. A reserved page-size code on the selected row raises an error flag.

Top module: `dram_row_decoder`

## Requirements
- R1: After a synchronous active-low reset, every boundary, page code and banks bit is zero, so every address reports a miss.
- R2: A write with `cfg_we` high loads `cfg_wdata` on the next rising clock edge. Addresses 0 to 7 load the end boundary of rows 0 to 7. Address 8 loads page-code bits [7:0] and address 9 loads bits [15:8], with row n's code held in bits [2n+1:2n]. Address 10 loads the banks field, where bit n belongs to row n. Addresses 11 to 15 change nothing. A lookup in the same cycle as a write still sees the old value.
- R3: With ordered boundaries, row n is hit when end(n-1) <= addr[31:23] < end(n), where end(-1) is 0. `row_hit` is then one-hot with bit n set, and `row_idx` equals n.
- R4: An empty row is never hit. Its address range belongs to the next row that has a nonzero span.
- R5: When addr[31:23] >= end(7), `miss` is 1 and `row_hit`, `row_idx`, `page_code`, `four_banks` and `page_err` are all zero.
- R6: When EDO mode is off, `page_code` is the selected row's code (00 = 2 KB, 01 = 4 KB, 10 = 8 KB, 11 = reserved).
- R7: `four_banks` is the banks bit of the selected row (1 = four banks, 0 = two banks). The bits of empty rows never reach the output.
- R8: While `mem_is_edo` is 1, `page_code` is 00 and `page_err` is 0, whatever the stored codes are.
- R9: `page_err` is 1 exactly when a row is selected, EDO mode is off, and that row's code is 11.
- R10: A change of `lookup_addr` shows on every lookup output in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register select: 0-7 boundaries, 8-9 page-code bytes, 10 banks field |
| cfg_wdata | input | 8 | Write data |
| mem_is_edo | input | 1 | High when the memory is EDO; forces a 2 KB page |
| lookup_addr | input | 32 | Physical address to decode |
| row_hit | output | 8 | One-hot row select, zero on a miss |
| row_idx | output | 3 | Index of the selected row |
| page_code | output | 2 | Page-size code of the selected row |
| four_banks | output | 1 | Banks flag of the selected row |
| miss | output | 1 | Address at or above the last boundary |
| page_err | output | 1 | Selected row carries the reserved page code |

## Verification
The one-hot, index and coverage assertions assume the boundaries never decrease from row 0 to row 7. The design computes an ordering flag and these assertions hold only while that flag is set. Every boundary set the stimulus loads keeps the order, including the single boundary rewritten in the middle of the run. The EDO, miss and error assertions do not depend on this order. They take `mem_is_edo` and the address as free inputs, which the bench changes on falling edges only.

// File: rtl/rowdec_pkg.sv
// Shared types and constants for the DRAM row boundary decoder.
// Assumes byte-wide configuration writes.
package rowdec_pkg;
    localparam int BYTE_W = 8;
    localparam int PCODE_W = 2;

    typedef enum logic [PCODE_W-1:0] {
        PG_2K   = 2'b00,
        PG_4K   = 2'b01,
        PG_8K   = 2'b10,
        PG_RSVD = 2'b11
    } page_code_e;
endpackage

// File: rtl/rowdec_regs.sv
// Configuration store: per-row end boundaries, packed page-size codes and
// the banks field. Written one byte at a time; a write lands on the next clock.
// Assumes the register map: rows first, then page bytes, then banks bytes.
module rowdec_regs
    import rowdec_pkg::*;
#(
    parameter int NUM_ROWS = 8,
    parameter int CFG_AW   = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_we,
    input  logic [CFG_AW-1:0]           cfg_addr,
    input  logic [BYTE_W-1:0]           cfg_wdata,
    output logic [NUM_ROWS*BYTE_W-1:0]  bnd_flat,
    output logic [NUM_ROWS*PCODE_W-1:0] page_flat,
    output logic [NUM_ROWS-1:0]         banks_vec
);
    localparam int PS_BYTES = (NUM_ROWS*PCODE_W + BYTE_W - 1) / BYTE_W;
    localparam int BK_BYTES = (NUM_ROWS + BYTE_W - 1) / BYTE_W;
    localparam int PS_BASE  = NUM_ROWS;
    localparam int BK_BASE  = NUM_ROWS + PS_BYTES;

    logic [PS_BYTES*BYTE_W-1:0] page_pad;
    logic [BK_BYTES*BYTE_W-1:0] banks_pad;

    for (genvar g = 0; g < NUM_ROWS; g++) begin : g_bnd
        // Boundary register for row g.
        always_ff @(posedge clk) begin
            if (!rst_n)
                bnd_flat[g*BYTE_W +: BYTE_W] <= '0;
            else if (cfg_we && cfg_addr == CFG_AW'(g))
                bnd_flat[g*BYTE_W +: BYTE_W] <= cfg_wdata;
        end

        a_r2_bnd_load: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we && cfg_addr == CFG_AW'(g)) |=> bnd_flat[g*BYTE_W +: BYTE_W] == $past(cfg_wdata));
        a_r2_bnd_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !(cfg_we && cfg_addr == CFG_AW'(g)) |=> $stable(bnd_flat[g*BYTE_W +: BYTE_W]));
    end

    for (genvar p = 0; p < PS_BYTES; p++) begin : g_page
        // One byte of the packed page-size codes.
        always_ff @(posedge clk) begin
            if (!rst_n)
                page_pad[p*BYTE_W +: BYTE_W] <= '0;
            else if (cfg_we && cfg_addr == CFG_AW'(PS_BASE + p))
                page_pad[p*BYTE_W +: BYTE_W] <= cfg_wdata;
        end
    end

    for (genvar b = 0; b < BK_BYTES; b++) begin : g_banks
        // One byte of the banks-per-row field.
        always_ff @(posedge clk) begin
            if (!rst_n)
                banks_pad[b*BYTE_W +: BYTE_W] <= '0;
            else if (cfg_we && cfg_addr == CFG_AW'(BK_BASE + b))
                banks_pad[b*BYTE_W +: BYTE_W] <= cfg_wdata;
        end
    end

    assign page_flat = page_pad[NUM_ROWS*PCODE_W-1:0];
    assign banks_vec = banks_pad[NUM_ROWS-1:0];
endmodule

// File: rtl/rowdec_match.sv
// Per-row range compare: each row claims the units from the previous end up
// to its own end, exclusive. Also flags a miss above the last end and reports
// whether the boundaries are non-decreasing.
// Assumes the unit field is at least one byte wide.
module rowdec_match
    import rowdec_pkg::*;
#(
    parameter int NUM_ROWS = 8,
    parameter int UNIT_W   = 9
) (
    input  logic [UNIT_W-1:0]          units,
    input  logic [NUM_ROWS*BYTE_W-1:0] bnd_flat,
    output logic [NUM_ROWS-1:0]        row_hit,
    output logic                       miss,
    output logic                       bnd_ordered
);
    localparam int CMP_W = (UNIT_W > BYTE_W) ? UNIT_W : BYTE_W;

    logic [CMP_W-1:0]    u_ext;
    logic [NUM_ROWS-1:0] hit_raw;

    assign u_ext = CMP_W'(units);

    for (genvar g = 0; g < NUM_ROWS; g++) begin : g_row
        logic [CMP_W-1:0] lo_ext;
        logic [CMP_W-1:0] hi_ext;
        if (g == 0) begin : g_first
            assign lo_ext = '0;
        end else begin : g_rest
            assign lo_ext = CMP_W'(bnd_flat[(g-1)*BYTE_W +: BYTE_W]);
        end
        assign hi_ext = CMP_W'(bnd_flat[g*BYTE_W +: BYTE_W]);
        // Range test for row g.
        always_comb hit_raw[g] = (u_ext >= lo_ext) && (u_ext < hi_ext);
    end

    // Miss when the address is at or past the top end.
    always_comb miss = u_ext >= CMP_W'(bnd_flat[(NUM_ROWS-1)*BYTE_W +: BYTE_W]);

    // Hits are suppressed on a miss.
    always_comb row_hit = hit_raw & {NUM_ROWS{~miss}};

    // Non-decreasing boundary check used by the assertions.
    always_comb begin
        bnd_ordered = 1'b1;
        for (int i = 1; i < NUM_ROWS; i++)
            if (bnd_flat[i*BYTE_W +: BYTE_W] < bnd_flat[(i-1)*BYTE_W +: BYTE_W])
                bnd_ordered = 1'b0;
    end
endmodule

// File: rtl/rowdec_select.sv
// Picks the lowest hit row and muxes out its page code and banks bit.
// EDO mode pins the code to 2 KB; a reserved code on the pick sets an error.
// Assumes row_hit is one-hot or zero when boundaries are ordered.
module rowdec_select
    import rowdec_pkg::*;
#(
    parameter int NUM_ROWS = 8,
    parameter int IDX_W    = 3
) (
    input  logic [NUM_ROWS-1:0]         row_hit,
    input  logic [NUM_ROWS*PCODE_W-1:0] page_flat,
    input  logic [NUM_ROWS-1:0]         banks_vec,
    input  logic                        mem_is_edo,
    output logic [IDX_W-1:0]            row_idx,
    output logic [PCODE_W-1:0]          page_code,
    output logic                        four_banks,
    output logic                        page_err
);
    logic             any_hit;
    logic [IDX_W-1:0] idx;
    page_code_e       code_raw;

    // Priority encode, lowest row wins.
    always_comb begin
        idx     = '0;
        any_hit = 1'b0;
        for (int i = NUM_ROWS-1; i >= 0; i--) begin
            if (row_hit[i]) begin
                idx     = IDX_W'(i);
                any_hit = 1'b1;
            end
        end
    end

    // Fetch the selected row's stored code.
    always_comb code_raw = page_code_e'(page_flat[int'(idx)*PCODE_W +: PCODE_W]);

    // Drive outputs, quiet when nothing is selected.
    always_comb begin
        row_idx    = any_hit ? idx : '0;
        four_banks = any_hit && banks_vec[idx];
        page_code  = (any_hit && !mem_is_edo) ? code_raw : PG_2K;
        page_err   = any_hit && !mem_is_edo && (code_raw == PG_RSVD);
    end
endmodule

// File: rtl/dram_row_decoder.sv
// DRAM row boundary decoder top. Splits the address into 8 MB units, matches
// it against the cumulative row ends and reports the row with its attributes.
// Assumes boundaries are programmed non-decreasing; lookup is combinational.
module dram_row_decoder
    import rowdec_pkg::*;
#(
    parameter int NUM_ROWS = 8,
    parameter int ADDR_W   = 32,
    parameter int UNIT_LSB = 23,
    parameter int CFG_AW   = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic [CFG_AW-1:0]      cfg_addr,
    input  logic [BYTE_W-1:0]      cfg_wdata,
    input  logic                   mem_is_edo,
    input  logic [ADDR_W-1:0]      lookup_addr,
    output logic [NUM_ROWS-1:0]    row_hit,
    output logic [$clog2(NUM_ROWS)-1:0] row_idx,
    output logic [PCODE_W-1:0]     page_code,
    output logic                   four_banks,
    output logic                   miss,
    output logic                   page_err
);
    localparam int IDX_W  = $clog2(NUM_ROWS);
    localparam int UNIT_W = ADDR_W - UNIT_LSB;

    logic [NUM_ROWS*BYTE_W-1:0]  bnd_flat;
    logic [NUM_ROWS*PCODE_W-1:0] page_flat;
    logic [NUM_ROWS-1:0]         banks_vec;
    logic [UNIT_W-1:0]           units;
    logic                        bnd_ordered;
    logic                        unused_low;

    assign units      = lookup_addr[ADDR_W-1:UNIT_LSB];
    assign unused_low = ^lookup_addr[UNIT_LSB-1:0];

    rowdec_regs #(.NUM_ROWS(NUM_ROWS), .CFG_AW(CFG_AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .bnd_flat  (bnd_flat),
        .page_flat (page_flat),
        .banks_vec (banks_vec)
    );

    rowdec_match #(.NUM_ROWS(NUM_ROWS), .UNIT_W(UNIT_W)) u_match (
        .units       (units),
        .bnd_flat    (bnd_flat),
        .row_hit     (row_hit),
        .miss        (miss),
        .bnd_ordered (bnd_ordered)
    );

    rowdec_select #(.NUM_ROWS(NUM_ROWS), .IDX_W(IDX_W)) u_select (
        .row_hit    (row_hit),
        .page_flat  (page_flat),
        .banks_vec  (banks_vec),
        .mem_is_edo (mem_is_edo),
        .row_idx    (row_idx),
        .page_code  (page_code),
        .four_banks (four_banks),
        .page_err   (page_err)
    );

    a_r3_onehot_hit: assert property (@(posedge clk) disable iff (!rst_n)
        bnd_ordered |-> $onehot0(row_hit));
    a_r3_idx_points_at_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (bnd_ordered && !miss) |-> row_hit[row_idx]);
    a_r4_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (bnd_ordered && !miss) |-> (row_hit != '0));
    a_r5_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        miss |-> (row_idx == '0 && page_code == PG_2K && !four_banks && !page_err));
    a_r8_edo_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        mem_is_edo |-> (page_code == PG_2K && !page_err));
    a_r9_err_only_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        page_err |-> (page_code == PG_RSVD && !miss));
endmodule

// File: tb/tb_dram_row_decoder.sv
module tb_dram_row_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        mem_is_edo = 1'b0;
    logic [31:0] lookup_addr = '0;
    logic [7:0]  row_hit;
    logic [2:0]  row_idx;
    logic [1:0]  page_code;
    logic        four_banks, miss, page_err;

    always #10 clk = ~clk;

    dram_row_decoder dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .mem_is_edo(mem_is_edo), .lookup_addr(lookup_addr),
        .row_hit(row_hit), .row_idx(row_idx), .page_code(page_code),
        .four_banks(four_banks), .miss(miss), .page_err(page_err)
    );

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    // Reference state, updated only at a clock edge that samples a write.
    int   m_bnd[8];
    int   m_page;
    int   m_banks;

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, compare mid-low phase, then
    // mirror any write into the model after the rising edge.
    task automatic step(string tag, bit we, int a, int d, int u, bit edo);
        int sel, lo, code, e_hit, e_idx, e_code, e_bk, e_err;
        bit e_miss;
        @(negedge clk);
        cfg_we      = we;
        cfg_addr    = 4'(a);
        cfg_wdata   = 8'(d);
        mem_is_edo  = edo;
        lookup_addr = {9'(u), 23'($urandom)};
        #5;
        e_miss = (u >= m_bnd[7]);
        sel = -1;
        for (int r = 0; r < 8; r++) begin
            lo = (r == 0) ? 0 : m_bnd[r-1];
            if (sel < 0 && u >= lo && u < m_bnd[r]) sel = r;
        end
        if (e_miss) sel = -1;
        e_hit = 0; e_idx = 0; e_code = 0; e_bk = 0; e_err = 0;
        if (sel >= 0) begin
            code  = (m_page >> (2*sel)) & 3;
            e_hit = 1 << sel;
            e_idx = sel;
            e_bk  = (m_banks >> sel) & 1;
            e_code = edo ? 0 : code;
            e_err  = (!edo && code == 3) ? 1 : 0;
        end
        chk(tag, "R3 R4 R10 row_hit", int'(row_hit), e_hit);
        chk(tag, "R5 miss", int'(miss), int'(e_miss));
        chk(tag, "R3 row_idx", int'(row_idx), e_idx);
        chk(tag, "R6 R8 page_code", int'(page_code), e_code);
        chk(tag, "R7 four_banks", int'(four_banks), e_bk);
        chk(tag, "R9 page_err", int'(page_err), e_err);
        @(posedge clk);
        #1;
        if (we) begin
            if (a < 8)       m_bnd[a] = d & 255;
            else if (a == 8) m_page = (m_page & 16'hFF00) | (d & 255);
            else if (a == 9) m_page = (m_page & 16'h00FF) | ((d & 255) << 8);
            else if (a == 10) m_banks = d & 255;
        end
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog all actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) m_bnd[i] = 0;
        m_page = 0;
        m_banks = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: everything cleared, all lookups miss.
        step("R1", 0, 0, 0, 0, 0);
        step("R1", 0, 0, 0, 1, 0);
        step("R1", 0, 0, 0, 100, 0);
        step("R1", 0, 0, 0, 300, 0);

        // R2: program rows with empty rows 1, 4 and 7.
        step("R2", 1, 0, 4, 2, 0);
        step("R2", 1, 1, 4, 2, 0);
        step("R2", 1, 2, 12, 2, 0);
        step("R2", 1, 3, 20, 5, 0);
        step("R2", 1, 4, 20, 5, 0);
        step("R2", 1, 5, 40, 5, 0);
        step("R2", 1, 6, 64, 5, 0);
        step("R2", 1, 7, 64, 5, 0);
        step("R2", 1, 8, 8'h2D, 10, 0);
        step("R2", 1, 9, 8'h9F, 10, 0);
        step("R2", 1, 10, 8'h5B, 10, 0);
        // R2: unmapped addresses change nothing.
        for (int a = 11; a < 16; a++) step("R2", 1, a, 8'hFF, 30, 0);

        // R3/R4/R6/R7/R9: sweep every unit across all rows and past the top.
        for (int u = 0; u < 70; u++) step("R3", 0, 0, 0, u, 0);
        // R5: addresses well above the top end.
        for (int u = 250; u < 262; u++) step("R5", 0, 0, 0, u, 0);
        step("R5", 0, 0, 0, 511, 0);
        // R8: EDO pins the page code.
        for (int u = 0; u < 70; u++) step("R8", 0, 0, 0, u, 1);

        // R2/R10: write while looking up; old value seen, new value next cycle.
        step("R2", 1, 0, 2, 3, 0);
        step("R2", 0, 0, 0, 3, 0);
        step("R10", 0, 0, 0, 1, 0);
        step("R10", 0, 0, 0, 2, 0);

        // Second layout: one unit per row, different codes and banks.
        for (int r = 0; r < 8; r++) step("R2", 1, r, r + 1, 0, 0);
        step("R2", 1, 8, 8'h00, 0, 0);
        step("R2", 1, 9, 8'hE4, 0, 0);
        step("R2", 1, 10, 8'hA5, 0, 0);
        for (int u = 0; u < 12; u++) step("R6", 0, 0, 0, u, 0);
        for (int u = 0; u < 12; u++) step("R7", 0, 0, 0, u, 1);

        // R1: reset again clears the store.
        @(negedge clk);
        cfg_we = 1'b0;
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        for (int i = 0; i < 8; i++) m_bnd[i] = 0;
        m_page = 0;
        m_banks = 0;
        @(negedge clk);
        rst_n = 1'b1;
        step("R1", 0, 0, 0, 0, 0);
        step("R1", 0, 0, 0, 4, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule